// File: doc/BRIEF.md
# Compressed stack-instruction micro-op expander

This block sits in the fetch path, next to the ordinary compressed decoder. It takes one 16-bit compressed stack instruction and turns it into a sequence of ordinary 32-bit instructions, offering one of them per cycle on a valid/ready port. The stack instructions are: a register-save push, a register-restore pop, a pop that returns, a pop that zeroes the return value and returns, and two moves that copy a register pair.

The upstream stage holds the compressed word and its valid flag steady while a sequence runs. It advances its program counter only when a micro-op flagged as last is accepted. A micro-op counts as accepted only in a cycle where the consumer is ready and the jump/flush strobe is low. A flush abandons the sequence and returns the sequencer to idle. Each micro-op carries the source 16-bit word so that a tracer can attribute it to that word.

The sequencer has these states:
- `PH_IDLE`: no sequence in progress.
- `PH_REGS`: one store or load per listed register.
- `PH_ZERO`: clear the return-value register.
- `PH_SPADJ`: stack pointer update.
- `PH_RET`: return jump.
- `PH_MV1` and `PH_MV2`: the two moves.

Its transitions are:
- IDLE→REGS or IDLE→MV1 on the first non-last acceptance.
- REGS→REGS while registers remain.
- REGS→ZERO (zeroing pop) or REGS→SPADJ when the last register is accepted.
- ZERO→SPADJ.
- SPADJ→RET for the returning pops, or SPADJ→IDLE otherwise.
- RET→IDLE.
- MV1→MV2, then MV2→IDLE.
- Any state→IDLE on flush.

In IDLE the first micro-op is offered combinationally from the held word, so a sequence costs no extra cycle at its start.

Top module: `sux_expander`

## Requirements
- R1: Recognised words have bits [1:0]=2'b10. For push/pop, bits [15:13]=3'b101 and bits [12:8] are 11000 (push), 11010 (pop), 11100 (zeroing return pop) or 11110 (return pop), with the register list in [7:4] and the stack immediate in [3:2]. For moves, bits [15:10]=6'b101011, bits [6:5]=01 (save pair: s-reg←a0/a1) or 11 (load pair: a0/a1←s-reg), with the first register in [9:7] and the second in [4:2]. `out_valid` is high only when `in_valid` is high and the word is a legal stack word; any other word gives `out_valid=0` and `illegal=0`.
- R2: The register list value 4 selects ra (x1) alone. Values 5..14 add s0 (x8), s1 (x9) and then s2..s9 (x18..x25) one per step. Value 15 selects ra and s0..s11 (13 registers). A push/pop word with list value 0..3 raises `illegal` with `out_valid=0`.
- R3: The stack adjustment is a base plus 16 times the stack immediate. The base is 16 bytes for list values 4..7, 32 for 8..11, 48 for 12..14 and 64 for 15.
- R4: A push with N listed registers emits N stores `sw reg(i), -4*(i+1)(x2)` for list element i=0 (ra) up to N-1, in that order. It then emits `addi x2,x2,-adj`. The encodings are: sw is {imm[11:5],rs2,rs1,010,imm[4:0],0100011}; addi is {imm,rs1,000,rd,0010011}.
- R5: A pop emits N loads `lw reg(i), adj-4*(i+1)(x2)` for i=N-1 down to 0, then `addi x2,x2,adj`. The lw encoding is {imm,rs1,010,rd,0000011}.
- R6: The return pop appends `jalr x0,0(x1)`, encoded {12'h0,x1,000,x0,1100111}, after the pop sequence. The zeroing return pop inserts `addi x10,x0,0` between the loads and the stack update, and also ends with the return jump.
- R7: The save-pair move emits `addi r1,x10,0` then `addi r2,x11,0`. The load-pair move emits `addi x10,r1,0` then `addi x11,r2,0`. A 3-bit field f maps to x8+f for f<2 and to x16+f otherwise.
- R8: The sequence advances only in a cycle with `out_valid`, `out_ready` and no `flush`. While stalled, the same micro-op stays on `out_instr`.
- R9: A flush returns the sequencer to idle. With the word still held, the next micro-op offered is the first one of its sequence.
- R10: `out_last` is high exactly on the final micro-op of each sequence.
- R11: `out_src` equals the compressed word on every offered micro-op.
- R12: `expanding` is high from the cycle after the first accepted non-last micro-op until the last micro-op is accepted or a flush occurs. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compressed word present |
| in_instr | input | 16 | Compressed word, held until its last micro-op is accepted |
| flush | input | 1 | Jump/flush strobe, aborts the sequence |
| out_ready | input | 1 | Consumer accepts the offered micro-op |
| out_valid | output | 1 | A micro-op is offered |
| out_instr | output | 32 | Expanded 32-bit micro-op |
| out_last | output | 1 | Offered micro-op is the final one |
| out_src | output | 16 | Source compressed word for tracing |
| expanding | output | 1 | A sequence is part-way through |
| illegal | output | 1 | Push/pop word with a reserved register list |

## Verification
The bench builds the block with both instruction groups enabled: `EN_PUSHPOP=1` and `EN_MOVES=1`. This brings every stack kind, every register-list value from 4 to 15 and all four stack immediates within reach. The random sequences are mixed with randomly stalled consumer cycles, so every state is seen both held and advancing. Directed cases cover a flush in the middle of a push, the reserved list values, and words outside the stack group.

// File: rtl/sux_pkg.sv
package sux_pkg;

    localparam int ILEN = 32;
    localparam int CLEN = 16;
    localparam int RW   = 5;
    localparam logic [RW-1:0] REG_ZERO = 5'd0;
    localparam logic [RW-1:0] REG_RA   = 5'd1;
    localparam logic [RW-1:0] REG_SP   = 5'd2;
    localparam logic [RW-1:0] REG_A0   = 5'd10;
    localparam logic [RW-1:0] REG_A1   = 5'd11;

    typedef enum logic [2:0] {
        OP_NONE, OP_PUSH, OP_POP, OP_POPRET, OP_POPRETZ, OP_MVSA, OP_MVAS
    } sux_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_REGS, PH_ZERO, PH_SPADJ, PH_RET, PH_MV1, PH_MV2
    } sux_phase_e;

    // number of registers named by a list value (0 for reserved values)
    function automatic logic [3:0] list_count(input logic [3:0] rl);
        logic [3:0] n;
        unique case (rl)
            4'd4:  n = 4'd1;
            4'd5:  n = 4'd2;
            4'd6:  n = 4'd3;
            4'd7:  n = 4'd4;
            4'd8:  n = 4'd5;
            4'd9:  n = 4'd6;
            4'd10: n = 4'd7;
            4'd11: n = 4'd8;
            4'd12: n = 4'd9;
            4'd13: n = 4'd10;
            4'd14: n = 4'd11;
            4'd15: n = 4'd13;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

    // base stack adjustment in bytes
    function automatic logic [7:0] list_base(input logic [3:0] rl);
        logic [7:0] b;
        unique case (rl)
            4'd4, 4'd5, 4'd6, 4'd7:   b = 8'd16;
            4'd8, 4'd9, 4'd10, 4'd11: b = 8'd32;
            4'd12, 4'd13, 4'd14:      b = 8'd48;
            4'd15:                    b = 8'd64;
            default:                  b = 8'd0;
        endcase
        return b;
    endfunction

    // architectural register of list element idx (0 = ra)
    function automatic logic [RW-1:0] list_reg(input logic [3:0] idx);
        if (idx == 4'd0)      return REG_RA;
        else if (idx < 4'd3)  return RW'(idx) + 5'd7;
        else                  return RW'(idx) + 5'd15;
    endfunction

    function automatic logic [RW-1:0] pair_reg(input logic [2:0] f);
        if (f < 3'd2) return RW'(f) + 5'd8;
        else          return RW'(f) + 5'd16;
    endfunction

    function automatic logic [ILEN-1:0] enc_sw(input logic [RW-1:0] src,
                                              input logic [RW-1:0] base,
                                              input logic [11:0] imm);
        return {imm[11:5], src, base, 3'b010, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [ILEN-1:0] enc_lw(input logic [RW-1:0] dst,
                                              input logic [RW-1:0] base,
                                              input logic [11:0] imm);
        return {imm, base, 3'b010, dst, 7'b0000011};
    endfunction

    function automatic logic [ILEN-1:0] enc_addi(input logic [RW-1:0] dst,
                                                input logic [RW-1:0] src,
                                                input logic [11:0] imm);
        return {imm, src, 3'b000, dst, 7'b0010011};
    endfunction

    function automatic logic [ILEN-1:0] enc_ret();
        return {12'h000, REG_RA, 3'b000, REG_ZERO, 7'b1100111};
    endfunction

endpackage

// File: rtl/sux_decode.sv
module sux_decode
    import sux_pkg::*;
#(
    parameter bit EN_PUSHPOP = 1'b1,
    parameter bit EN_MOVES   = 1'b1
) (
    input  logic [CLEN-1:0] word,
    output sux_kind_e       kind,
    output logic            reserved,
    output logic [3:0]      count,
    output logic [7:0]      adj
);
    logic       quad_ok;
    logic       pp_grp;
    logic       mv_grp;
    sux_kind_e  pp_kind;
    sux_kind_e  mv_kind;
    logic [3:0] rl;

    assign quad_ok = (word[1:0] == 2'b10);
    assign rl      = word[7:4];
    assign count   = list_count(rl);
    assign adj     = list_base(rl) + {2'b00, word[3:2], 4'b0000};

    generate
        if (EN_PUSHPOP) begin : g_pp
            always_comb begin
                pp_kind = OP_NONE;
                if (quad_ok && word[15:13] == 3'b101) begin
                    unique case (word[12:8])
                        5'b11000: pp_kind = OP_PUSH;
                        5'b11010: pp_kind = OP_POP;
                        5'b11100: pp_kind = OP_POPRETZ;
                        5'b11110: pp_kind = OP_POPRET;
                        default:  pp_kind = OP_NONE;
                    endcase
                end
            end
        end else begin : g_no_pp
            assign pp_kind = OP_NONE;
        end

        if (EN_MOVES) begin : g_mv
            always_comb begin
                mv_kind = OP_NONE;
                if (quad_ok && word[15:10] == 6'b101011) begin
                    if (word[6:5] == 2'b01)      mv_kind = OP_MVSA;
                    else if (word[6:5] == 2'b11) mv_kind = OP_MVAS;
                end
            end
        end else begin : g_no_mv
            assign mv_kind = OP_NONE;
        end
    endgenerate

    assign pp_grp   = (pp_kind != OP_NONE);
    assign mv_grp   = (mv_kind != OP_NONE);
    assign reserved = pp_grp && (count == 4'd0);

    always_comb begin
        if (pp_grp && !reserved) kind = pp_kind;
        else if (mv_grp)         kind = mv_kind;
        else                     kind = OP_NONE;
    end

endmodule

// File: rtl/sux_uop_build.sv
module sux_uop_build
    import sux_pkg::*;
(
    input  sux_kind_e       kind,
    input  sux_phase_e      phase,
    input  logic [3:0]      off,
    input  logic [7:0]      adj,
    input  logic [2:0]      mv_r1,
    input  logic [2:0]      mv_r2,
    output logic [ILEN-1:0] uop
);
    logic [11:0]   byte_off;
    logic [11:0]   adj12;
    logic [RW-1:0] lreg;

    assign byte_off = {6'b000000, off, 2'b00};
    assign adj12    = {4'b0000, adj};
    assign lreg     = list_reg(off - 4'd1);

    always_comb begin
        uop = '0;
        unique case (phase)
            PH_REGS: begin
                if (kind == OP_PUSH) uop = enc_sw(lreg, REG_SP, 12'd0 - byte_off);
                else                 uop = enc_lw(lreg, REG_SP, adj12 - byte_off);
            end
            PH_ZERO:  uop = enc_addi(REG_A0, REG_ZERO, 12'd0);
            PH_SPADJ: uop = enc_addi(REG_SP, REG_SP,
                                     (kind == OP_PUSH) ? (12'd0 - adj12) : adj12);
            PH_RET:   uop = enc_ret();
            PH_MV1: begin
                if (kind == OP_MVSA) uop = enc_addi(pair_reg(mv_r1), REG_A0, 12'd0);
                else                 uop = enc_addi(REG_A0, pair_reg(mv_r1), 12'd0);
            end
            PH_MV2: begin
                if (kind == OP_MVSA) uop = enc_addi(pair_reg(mv_r2), REG_A1, 12'd0);
                else                 uop = enc_addi(REG_A1, pair_reg(mv_r2), 12'd0);
            end
            default: uop = '0;
        endcase
    end

endmodule

// File: rtl/sux_expander.sv
module sux_expander
    import sux_pkg::*;
#(
    parameter bit EN_PUSHPOP = 1'b1,
    parameter bit EN_MOVES   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_instr,
    input  logic        flush,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [31:0] out_instr,
    output logic        out_last,
    output logic [15:0] out_src,
    output logic        expanding,
    output logic        illegal
);
    sux_kind_e  kind;
    logic       reserved;
    logic [3:0] count;
    logic [7:0] adj;

    sux_phase_e st_q, st_d;
    logic [3:0] cnt_q, cnt_d;
    logic [3:0] off_q, off_d;

    sux_phase_e cur_ph;
    logic [3:0] cur_cnt;
    logic [3:0] cur_off;
    logic       is_mv;
    logic       is_ret;
    logic       fire;

    sux_decode #(
        .EN_PUSHPOP (EN_PUSHPOP),
        .EN_MOVES   (EN_MOVES)
    ) u_decode (
        .word     (in_instr),
        .kind     (kind),
        .reserved (reserved),
        .count    (count),
        .adj      (adj)
    );

    assign is_mv  = (kind == OP_MVSA) || (kind == OP_MVAS);
    assign is_ret = (kind == OP_POPRET) || (kind == OP_POPRETZ);

    // in idle the first micro-op comes straight from the held word
    always_comb begin
        if (st_q == PH_IDLE) begin
            cur_ph  = (kind == OP_NONE) ? PH_IDLE : (is_mv ? PH_MV1 : PH_REGS);
            cur_cnt = count;
            cur_off = (kind == OP_PUSH) ? 4'd1 : count;
        end else begin
            cur_ph  = st_q;
            cur_cnt = cnt_q;
            cur_off = off_q;
        end
    end

    sux_uop_build u_build (
        .kind  (kind),
        .phase (cur_ph),
        .off   (cur_off),
        .adj   (adj),
        .mv_r1 (in_instr[9:7]),
        .mv_r2 (in_instr[4:2]),
        .uop   (out_instr)
    );

    assign fire = out_valid && out_ready && !flush;

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        off_d = off_q;
        if (flush) begin
            st_d = PH_IDLE;
        end else if (fire) begin
            unique case (cur_ph)
                PH_REGS: begin
                    if (cur_cnt == 4'd1) begin
                        st_d = (kind == OP_POPRETZ) ? PH_ZERO : PH_SPADJ;
                    end else begin
                        st_d  = PH_REGS;
                        cnt_d = cur_cnt - 4'd1;
                        off_d = (kind == OP_PUSH) ? cur_off + 4'd1 : cur_off - 4'd1;
                    end
                end
                PH_ZERO:  st_d = PH_SPADJ;
                PH_SPADJ: st_d = is_ret ? PH_RET : PH_IDLE;
                PH_RET:   st_d = PH_IDLE;
                PH_MV1:   st_d = PH_MV2;
                PH_MV2:   st_d = PH_IDLE;
                default:  st_d = PH_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_IDLE;
            cnt_q <= 4'd0;
            off_q <= 4'd0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            off_q <= off_d;
        end
    end

    // output process
    always_comb begin
        out_valid = in_valid && (kind != OP_NONE);
        illegal   = in_valid && reserved;
        out_src   = in_instr;
        expanding = (st_q != PH_IDLE);
        unique case (cur_ph)
            PH_SPADJ: out_last = !is_ret;
            PH_RET:   out_last = 1'b1;
            PH_MV2:   out_last = 1'b1;
            default:  out_last = 1'b0;
        endcase
    end

endmodule

// File: rtl/sux_checker.sv
module sux_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_instr,
    input logic        flush,
    input logic        out_ready,
    input logic        out_valid,
    input logic [31:0] out_instr,
    input logic        out_last,
    input logic        expanding,
    input logic        illegal
);
    assert_illegal_novalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !out_valid);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) ##1 (in_valid && $stable(in_instr))
        |-> (out_valid && $stable(out_instr) && $stable(out_last)));

    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !expanding);

    assert_last_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !flush && out_last) |=> !expanding);

    assert_expand_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expanding) |-> $past(out_valid && out_ready && !flush && !out_last));

endmodule

bind sux_expander sux_checker u_sux_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_instr  (in_instr),
    .flush     (flush),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_instr (out_instr),
    .out_last  (out_last),
    .expanding (expanding),
    .illegal   (illegal)
);

// File: tb/sux_expander_bench.sv
module sux_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        flush = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_instr;
    logic        out_last;
    logic [15:0] out_src;
    logic        expanding;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sux_expander #(.EN_PUSHPOP(1'b1), .EN_MOVES(1'b1)) u_sux_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .flush(flush), .out_ready(out_ready), .out_valid(out_valid),
        .out_instr(out_instr), .out_last(out_last), .out_src(out_src),
        .expanding(expanding), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- reference model from the requirements ----
    function automatic int kind_of(input logic [15:0] w); // 1 push 2 pop 3 popret 4 popretz 5 mvsa 6 mvas
        if (w[1:0] != 2'b10) return 0;
        if (w[15:13] == 3'b101 && w[12:8] == 5'b11000) return 1;
        if (w[15:13] == 3'b101 && w[12:8] == 5'b11010) return 2;
        if (w[15:13] == 3'b101 && w[12:8] == 5'b11110) return 3;
        if (w[15:13] == 3'b101 && w[12:8] == 5'b11100) return 4;
        if (w[15:10] == 6'b101011 && w[6:5] == 2'b01) return 5;
        if (w[15:10] == 6'b101011 && w[6:5] == 2'b11) return 6;
        return 0;
    endfunction

    function automatic int n_regs(input logic [3:0] rl);
        if (rl == 4'd15) return 13;
        return int'(rl) - 3;
    endfunction

    function automatic int adj_of(input logic [15:0] w);
        int b;
        if (w[7:4] < 4'd8) b = 16;
        else if (w[7:4] < 4'd12) b = 32;
        else if (w[7:4] < 4'd15) b = 48;
        else b = 64;
        return b + 16 * int'(w[3:2]);
    endfunction

    function automatic logic [4:0] reg_of(input int i);
        if (i == 0) return 5'd1;
        if (i <= 2) return 5'(7 + i);
        return 5'(15 + i);
    endfunction

    function automatic logic [4:0] sreg(input logic [2:0] f);
        return (f < 3'd2) ? 5'(8 + f) : 5'(16 + f);
    endfunction

    function automatic logic [31:0] b_addi(input logic [4:0] rd, input logic [4:0] rs, input int imm);
        logic [11:0] i12 = 12'(imm);
        return {i12, rs, 3'b000, rd, 7'h13};
    endfunction

    function automatic int seq_len(input logic [15:0] w);
        case (kind_of(w))
            1, 2: return n_regs(w[7:4]) + 1;
            3:    return n_regs(w[7:4]) + 2;
            4:    return n_regs(w[7:4]) + 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [31:0] exp_uop(input logic [15:0] w, input int k);
        int n = n_regs(w[7:4]);
        int a = adj_of(w);
        int kd = kind_of(w);
        logic [11:0] im;
        int i;
        if (kd == 5) return (k == 0) ? b_addi(sreg(w[9:7]), 5'd10, 0) : b_addi(sreg(w[4:2]), 5'd11, 0);
        if (kd == 6) return (k == 0) ? b_addi(5'd10, sreg(w[9:7]), 0) : b_addi(5'd11, sreg(w[4:2]), 0);
        if (kd == 1) begin
            if (k < n) begin
                im = 12'(-4 * (k + 1));
                return {im[11:5], reg_of(k), 5'd2, 3'b010, im[4:0], 7'h23};
            end
            return b_addi(5'd2, 5'd2, -a);
        end
        if (k < n) begin
            i = n - 1 - k;
            im = 12'(a - 4 * (i + 1));
            return {im, 5'd2, 3'b010, reg_of(i), 7'h03};
        end
        if (kd == 4) begin
            if (k == n) return b_addi(5'd10, 5'd0, 0);
            if (k == n + 1) return b_addi(5'd2, 5'd2, a);
            return {12'h000, 5'd1, 3'b000, 5'd0, 7'h67};
        end
        if (k == n) return b_addi(5'd2, 5'd2, a);
        return {12'h000, 5'd1, 3'b000, 5'd0, 7'h67};
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (kind_of(w))
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [15:0] mk_pp(input logic [4:0] op, input logic [3:0] rl, input logic [1:0] sp);
        return {3'b101, op, rl, sp, 2'b10};
    endfunction

    function automatic logic [15:0] mk_mv(input bit load, input logic [2:0] r1, input logic [2:0] r2);
        return {6'b101011, r1, load ? 2'b11 : 2'b01, r2, 2'b10};
    endfunction

    // run one whole sequence; called at a negedge with the sequencer idle
    task automatic run_seq(input logic [15:0] w, input int stall_pct);
        int n = seq_len(w);
        int k = 0;
        in_valid = 1'b1;
        in_instr = w;
        while (k < n) begin
            out_ready = (($urandom % 100) >= stall_pct);
            #1;
            chk("R1 valid", {31'd0, out_valid}, 32'd1);
            chk(tag_of(w), out_instr, exp_uop(w, k));
            chk("R10 last", {31'd0, out_last}, {31'd0, k == n - 1});
            chk("R11 src", {16'd0, out_src}, {16'd0, w});
            chk("R12 expanding", {31'd0, expanding}, {31'd0, k != 0});
            @(negedge clk);
            if (out_ready) k++;
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        chk("R12 idle after last", {31'd0, expanding}, 32'd0);
        chk("R1 no word", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] w;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset expanding", {31'd0, expanding}, 32'd0);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: a word outside the stack group is not claimed
        in_valid = 1'b1;
        in_instr = 16'h4501;
        #1;
        chk("R1 foreign word valid", {31'd0, out_valid}, 32'd0);
        chk("R1 foreign word illegal", {31'd0, illegal}, 32'd0);
        @(negedge clk);

        // R2: reserved register lists
        for (int rl = 0; rl < 4; rl++) begin
            in_instr = mk_pp(5'b11010, 4'(rl), 2'd1);
            #1;
            chk("R2 reserved illegal", {31'd0, illegal}, 32'd1);
            chk("R2 reserved valid", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R2/R3/R4 directed: smallest list, largest list and immediate
        run_seq(mk_pp(5'b11000, 4'd4, 2'd0), 0);
        run_seq(mk_pp(5'b11000, 4'd15, 2'd3), 0);
        run_seq(mk_pp(5'b11010, 4'd15, 2'd3), 0);
        run_seq(mk_pp(5'b11100, 4'd14, 2'd2), 0);
        run_seq(mk_pp(5'b11110, 4'd8, 2'd1), 0);
        run_seq(mk_mv(1'b0, 3'd0, 3'd7), 0);
        run_seq(mk_mv(1'b1, 3'd5, 3'd1), 0);

        // R8: directed stall holds the micro-op
        w = mk_pp(5'b11000, 4'd6, 2'd0);
        in_valid = 1'b1;
        in_instr = w;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
            #1;
            chk("R8 stall hold", out_instr, exp_uop(w, 1));
            @(negedge clk);
        end
        // R9: flush in mid sequence returns to the first micro-op
        out_ready = 1'b1;
        flush = 1'b1;
        #1;
        chk("R8 flush not consumed", out_instr, exp_uop(w, 1));
        @(negedge clk);
        flush = 1'b0;
        out_ready = 1'b0;
        #1;
        chk("R9 restart after flush", out_instr, exp_uop(w, 0));
        chk("R9 idle after flush", {31'd0, expanding}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);

        // random mix
        for (int t = 0; t < 300; t++) begin
            int c = int'($urandom % 6);
            logic [3:0] rl = 4'(4 + ($urandom % 12));
            logic [1:0] sp = 2'($urandom % 4);
            case (c)
                0: w = mk_pp(5'b11000, rl, sp);
                1: w = mk_pp(5'b11010, rl, sp);
                2: w = mk_pp(5'b11110, rl, sp);
                3: w = mk_pp(5'b11100, rl, sp);
                4: w = mk_mv(1'b0, 3'($urandom % 8), 3'($urandom % 8));
                default: w = mk_mv(1'b1, 3'($urandom % 8), 3'($urandom % 8));
            endcase
            run_seq(w, 30);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule